// File: doc/BRIEF.md
# Chained Big-Integer Funnel Shifter

This block shifts a multi-digit integer held in its own digit store left or right by an amount taken from an input port. The integer is up to `NDIG` digits of 64 bits, with digit 0 the least significant. Each step builds one result digit by joining two neighbouring source digits into a 128-bit window and shifting it. The bits a plain shift would fill with zeros come from a 64-bit carry-in word. The bits a plain shift would drop are collected into a 64-bit carry-out word. Several invocations can therefore be chained across a longer number.

The amount splits into a whole-digit offset (`amount / 64`) and a sub-word amount (`amount % 64`). The offset picks which source digits feed the window. The sub-word amount is the funnel shift inside the window. The vector is rewritten in place. A left shift walks from the top digit downward and a right shift walks from the bottom digit upward, so no digit is overwritten while a later step still needs it. A host loads and reads digits through a simple write port and a combinational read port. It then pulses `start` and waits for the one-cycle `done` pulse.

Top module: `bigint_chain_shifter`

## Requirements
- R1: After reset `busy`, `done` and `carry_out` are 0 and every stored digit reads 0.
- R2: While `busy` is 0, a host write to index `i < NDIG` is visible on `host_rdata` (for `host_ridx = i`) from the next cycle. Host writes made while `busy` is 1 are ignored.
- R3: The source value is the `n` digits extended downward by `carry_in` at digit position -1 and by zeros below that. For a left shift by `s`, result digit `i` is bits `[64i+63:64i]` of the source value shifted left by `s`. This includes offsets of 0 and sub-word amounts from 1 to 63.
- R4: The source value is the `n` digits extended upward by `carry_in` at digit position `n` and by zeros above that. For a right shift by `s`, result digit `i` is bits `[64i+63:64i]` of the source value shifted right by `s`.
- R5: `carry_out` holds the 64 bits just beyond the vector after the shift. For a left shift this is digit `n` of the shifted value. For a right shift it is digit -1, the bits that fell below bit 0. It holds that value until the next operation.
- R6: With a sub-word amount of 0, every result digit is a whole source digit moved by the offset. When the offset is also 0, `carry_out` is 0.
- R7: An offset of 1 takes `carry_in` as the whole neighbouring digit. An offset of 2 or more fills the far positions with zeros.
- R8: `busy` rises the cycle after `start` is accepted and stays high for `n + 1` cycles. `done` is high for exactly one cycle, `n + 1` clock edges after the accepting edge.
- R9: A `start` pulse while `busy` is 1 is ignored. The running operation keeps its direction, amount, count and carry-in.
- R10: Digits at indices `n` and above are left unchanged by an operation.
- R11: A `count` above `NDIG` is treated as `NDIG`.
- R12: A left shift writes digits in descending index order and a right shift in ascending order. The carry-out step comes first in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| dir | input | 1 | 0 = shift toward the top (left), 1 = toward the bottom (right) |
| amount | input | AMT_W | Shift amount in bits |
| count | input | IDX_W | Number of digits `n` in the vector |
| carry_in | input | 64 | Word that fills the vacated side |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 64 | Bits shifted out past the vector |
| host_we | input | 1 | Host digit write enable |
| host_widx | input | IDX_W | Host write index |
| host_wdata | input | 64 | Host write data |
| host_ridx | input | IDX_W | Host read index |
| host_rdata | output | 64 | Digit at `host_ridx` (combinational) |

## Verification
`start` is driven on a falling edge. The rising edge that follows is counted as the accepting edge. `busy` is expected high on the next falling edge, and `done` is expected on the falling edge after the `n + 1`-th later rising edge. It is expected low again one edge after that. The carry-out and all digits are read only after `done`: the read port is combinational, so each index is sampled one delay after it is driven on a falling edge. Expected digits and the carry-out come from a wide shift of the concatenated source value in the bench. The R9 and R2 pokes are applied mid-run, and their absence of effect is read back from the final digits.

// File: rtl/bigsh_pkg.sv
package bigsh_pkg;

    localparam int DIGIT_W = 64;
    localparam int SUB_W   = 6;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shdir_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Two neighbouring source words forming a 128-bit window.
    typedef struct packed {
        digit_t upper;
        digit_t lower;
    } window_t;

    // Funnel shift of the window: left keeps the upper half, right the lower.
    function automatic digit_t funnel(shdir_e d, window_t w, logic [SUB_W-1:0] sub);
        logic [2*DIGIT_W-1:0] wide;
        wide = {w.upper, w.lower};
        if (d == DIR_LEFT) begin
            wide = wide << sub;
            return wide[2*DIGIT_W-1:DIGIT_W];
        end
        wide = wide >> sub;
        return wide[DIGIT_W-1:0];
    endfunction

endpackage

// File: rtl/bigsh_regfile.sv
module bigsh_regfile
    import bigsh_pkg::*;
#(
    parameter int NDIG  = 8,
    parameter int IDX_W = 4,
    parameter int NRD   = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  digit_t                    wdata,
    input  logic [NRD-1:0][IDX_W-1:0] raddr,
    output digit_t [NRD-1:0]          rdata
);
    localparam int AW = (NDIG > 1) ? $clog2(NDIG) : 1;

    digit_t mem [NDIG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NDIG; i++) mem[i] <= '0;
        end else if (we && widx < IDX_W'(NDIG)) begin
            mem[widx[AW-1:0]] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] < IDX_W'(NDIG)) ? mem[raddr[g][AW-1:0]] : '0;
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (we && widx < IDX_W'(NDIG)) |=> mem[$past(widx[AW-1:0])] == $past(wdata));

endmodule

// File: rtl/bigsh_seq.sv
module bigsh_seq
    import bigsh_pkg::*;
#(
    parameter int NDIG  = 8,
    parameter int IDX_W = 4,
    parameter int OFS_W = 6,
    parameter int POS_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  shdir_e                  dir_in,
    input  logic [OFS_W+SUB_W-1:0]  amount,
    input  logic [IDX_W-1:0]        count,
    input  digit_t                  cin_in,
    output logic                    busy,
    output logic                    done,
    output logic                    first,
    output shdir_e                  dir_q,
    output logic [OFS_W-1:0]        ofs_q,
    output logic [SUB_W-1:0]        sub_q,
    output logic [IDX_W-1:0]        n_q,
    output logic signed [POS_W-1:0] pos_q,
    output digit_t                  cin_q
);
    localparam int RW = $clog2(NDIG + 2);

    seq_state_e       state_q;
    logic [RW-1:0]    rem_q;
    logic [IDX_W-1:0] n_clamped;

    assign n_clamped = (count > IDX_W'(NDIG)) ? IDX_W'(NDIG) : count;
    assign busy      = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            first   <= 1'b0;
            dir_q   <= DIR_LEFT;
            ofs_q   <= '0;
            sub_q   <= '0;
            n_q     <= '0;
            pos_q   <= '0;
            rem_q   <= '0;
            cin_q   <= '0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (start) begin
                    state_q <= ST_RUN;
                    first   <= 1'b1;
                    dir_q   <= dir_in;
                    ofs_q   <= amount[OFS_W+SUB_W-1:SUB_W];
                    sub_q   <= amount[SUB_W-1:0];
                    n_q     <= n_clamped;
                    cin_q   <= cin_in;
                    rem_q   <= RW'(n_clamped) + RW'(1);
                    pos_q   <= (dir_in == DIR_LEFT) ? POS_W'(n_clamped) : '1;
                end
            end else begin
                first <= 1'b0;
                pos_q <= (dir_q == DIR_LEFT) ? pos_q - POS_W'(1) : pos_q + POS_W'(1);
                rem_q <= rem_q - RW'(1);
                if (rem_q == RW'(1)) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
            end
        end
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !first) |-> ($stable(ofs_q) && $stable(sub_q) && $stable(n_q)
                              && $stable(dir_q) && $stable(cin_q)));

    assert_walk_order_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && !first) |-> pos_q == ((dir_q == DIR_LEFT) ? $past(pos_q) - POS_W'(1)
                                                           : $past(pos_q) + POS_W'(1)));

endmodule

// File: rtl/bigsh_datapath.sv
module bigsh_datapath
    import bigsh_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int OFS_W = 6,
    parameter int POS_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    busy,
    input  logic                    first,
    input  shdir_e                  dir_q,
    input  logic [OFS_W-1:0]        ofs_q,
    input  logic [SUB_W-1:0]        sub_q,
    input  logic [IDX_W-1:0]        n_q,
    input  logic signed [POS_W-1:0] pos_q,
    input  digit_t                  cin_q,
    output logic [IDX_W-1:0]        rd_upper_idx,
    output logic [IDX_W-1:0]        rd_lower_idx,
    input  digit_t                  rd_upper,
    input  digit_t                  rd_lower,
    output logic                    wr_en,
    output logic [IDX_W-1:0]        wr_idx,
    output digit_t                  wr_data,
    output digit_t                  carry_out
);
    logic signed [POS_W-1:0] ofs_s, n_s, j_up, j_lo;
    logic                    up_in, lo_in, up_cin, lo_cin;
    window_t                 win;
    digit_t                  result;

    always_comb begin
        ofs_s = POS_W'(ofs_q);
        n_s   = POS_W'(n_q);
        if (dir_q == DIR_LEFT) begin
            j_up = pos_q - ofs_s;
            j_lo = pos_q - ofs_s - POS_W'(1);
        end else begin
            j_lo = pos_q + ofs_s;
            j_up = pos_q + ofs_s + POS_W'(1);
        end
        up_in  = (j_up >= 0) && (j_up < n_s);
        lo_in  = (j_lo >= 0) && (j_lo < n_s);
        up_cin = (dir_q == DIR_LEFT) ? (j_up == -1) : (j_up == n_s);
        lo_cin = (dir_q == DIR_LEFT) ? (j_lo == -1) : (j_lo == n_s);
        rd_upper_idx = up_in ? j_up[IDX_W-1:0] : '0;
        rd_lower_idx = lo_in ? j_lo[IDX_W-1:0] : '0;
        win.upper = up_in ? rd_upper : (up_cin ? cin_q : '0);
        win.lower = lo_in ? rd_lower : (lo_cin ? cin_q : '0);
        result    = funnel(dir_q, win, sub_q);
    end

    assign wr_en   = busy && !first;
    assign wr_idx  = pos_q[IDX_W-1:0];
    assign wr_data = result;

    always_ff @(posedge clk) begin
        if (rst) carry_out <= '0;
        else if (busy && first) carry_out <= result;
    end

    assert_write_in_range_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (pos_q >= 0) && (pos_q < n_s));

    assert_whole_digit_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sub_q == '0) |-> wr_data == ((dir_q == DIR_LEFT) ? win.upper : win.lower));

    assert_cout_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && first && sub_q == '0 && ofs_q == '0) |=> carry_out == '0);

endmodule

// File: rtl/bigint_chain_shifter.sv
module bigint_chain_shifter
    import bigsh_pkg::*;
#(
    parameter  int NDIG  = 8,
    parameter  int AMT_W = 12,
    localparam int IDX_W = $clog2(NDIG + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             dir,
    input  logic [AMT_W-1:0] amount,
    input  logic [IDX_W-1:0] count,
    input  logic [63:0]      carry_in,
    output logic             busy,
    output logic             done,
    output logic [63:0]      carry_out,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_widx,
    input  logic [63:0]      host_wdata,
    input  logic [IDX_W-1:0] host_ridx,
    output logic [63:0]      host_rdata
);
    localparam int OFS_W = AMT_W - SUB_W;
    localparam int POS_W = OFS_W + IDX_W + 2;

    logic                    first;
    shdir_e                  dir_q;
    logic [OFS_W-1:0]        ofs_q;
    logic [SUB_W-1:0]        sub_q;
    logic [IDX_W-1:0]        n_q;
    logic signed [POS_W-1:0] pos_q;
    digit_t                  cin_q;

    logic                    eng_we;
    logic [IDX_W-1:0]        eng_widx, idx_up, idx_lo;
    digit_t                  eng_wdata;

    logic                    rf_we;
    logic [IDX_W-1:0]        rf_widx;
    digit_t                  rf_wdata;
    logic [2:0][IDX_W-1:0]   rf_raddr;
    digit_t [2:0]            rf_rdata;

    bigsh_seq #(.NDIG(NDIG), .IDX_W(IDX_W), .OFS_W(OFS_W), .POS_W(POS_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .dir_in(shdir_e'(dir)),
        .amount(amount), .count(count), .cin_in(carry_in),
        .busy(busy), .done(done), .first(first), .dir_q(dir_q),
        .ofs_q(ofs_q), .sub_q(sub_q), .n_q(n_q), .pos_q(pos_q), .cin_q(cin_q)
    );

    bigsh_datapath #(.IDX_W(IDX_W), .OFS_W(OFS_W), .POS_W(POS_W)) u_dp (
        .clk(clk), .rst(rst), .busy(busy), .first(first), .dir_q(dir_q),
        .ofs_q(ofs_q), .sub_q(sub_q), .n_q(n_q), .pos_q(pos_q), .cin_q(cin_q),
        .rd_upper_idx(idx_up), .rd_lower_idx(idx_lo),
        .rd_upper(rf_rdata[0]), .rd_lower(rf_rdata[1]),
        .wr_en(eng_we), .wr_idx(eng_widx), .wr_data(eng_wdata),
        .carry_out(carry_out)
    );

    // The engine owns the write port while running; host writes then drop.
    assign rf_we    = busy ? eng_we    : host_we;
    assign rf_widx  = busy ? eng_widx  : host_widx;
    assign rf_wdata = busy ? eng_wdata : host_wdata;
    assign rf_raddr = {host_ridx, idx_lo, idx_up};

    bigsh_regfile #(.NDIG(NDIG), .IDX_W(IDX_W), .NRD(3)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
        .raddr(rf_raddr), .rdata(rf_rdata)
    );

    assign host_rdata = rf_rdata[2];

endmodule

// File: tb/test_bigint_chain_shifter.sv
module test_bigint_chain_shifter;
    localparam int NDIG  = 8;
    localparam int AMT_W = 12;
    localparam int IDX_W = $clog2(NDIG + 1);
    localparam int TW    = 64 * (NDIG + 2);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             dir = 1'b0;
    logic [AMT_W-1:0] amount = '0;
    logic [IDX_W-1:0] count = '0;
    logic [63:0]      carry_in = '0;
    logic             busy, done;
    logic [63:0]      carry_out;
    logic             host_we = 1'b0;
    logic [IDX_W-1:0] host_widx = '0;
    logic [63:0]      host_wdata = '0;
    logic [IDX_W-1:0] host_ridx = '0;
    logic [63:0]      host_rdata;

    int total = 0;
    int bad   = 0;

    logic [63:0] img [NDIG];
    logic [63:0] exp_d [NDIG];
    logic [63:0] exp_cout;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #5 clk = ~clk;

    bigint_chain_shifter #(.NDIG(NDIG), .AMT_W(AMT_W)) i_bigint_chain_shifter (
        .clk(clk), .rst(rst), .start(start), .dir(dir), .amount(amount),
        .count(count), .carry_in(carry_in), .busy(busy), .done(done),
        .carry_out(carry_out), .host_we(host_we), .host_widx(host_widx),
        .host_wdata(host_wdata), .host_ridx(host_ridx), .host_rdata(host_rdata)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] next_word();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    task automatic load_random();
        for (int i = 0; i < NDIG; i++) begin
            @(negedge clk);
            img[i]     = next_word();
            host_we    = 1'b1;
            host_widx  = IDX_W'(i);
            host_wdata = img[i];
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic verify_store(string tag);
        for (int i = 0; i < NDIG; i++) begin
            @(negedge clk);
            host_ridx = IDX_W'(i);
            #1;
            check(tag, host_rdata, img[i]);
        end
    endtask

    // Independent model: one wide shift of the concatenated source value.
    task automatic model(logic d, int amt, int n, logic [63:0] cin);
        logic [TW-1:0] t;
        t = '0;
        if (d == 1'b0) begin
            t[63:0] = cin;
            for (int j = 0; j < n; j++) t[64*(j+1) +: 64] = img[j];
            t = t << amt;
            exp_cout = t[64*(n+1) +: 64];
        end else begin
            for (int j = 0; j < n; j++) t[64*(j+1) +: 64] = img[j];
            t[64*(n+1) +: 64] = cin;
            t = t >> amt;
            exp_cout = t[63:0];
        end
        for (int i = 0; i < NDIG; i++) exp_d[i] = (i < n) ? t[64*(i+1) +: 64] : img[i];
    endtask

    task automatic run_op(string tag, logic d, int amt, int cnt, logic [63:0] cin, bit poke);
        int n;
        int cyc;
        n = (cnt > NDIG) ? NDIG : cnt;
        load_random();
        model(d, amt, n, cin);
        @(negedge clk);
        start    = 1'b1;
        dir      = d;
        amount   = AMT_W'(amt);
        count    = IDX_W'(cnt);
        carry_in = cin;
        @(posedge clk);
        @(negedge clk);
        start    = 1'b0;
        carry_in = ~cin;
        check({tag, " R8 busy"}, 64'(busy), 64'd1);
        cyc = 0;
        while (!done && cyc < 64) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (poke && cyc == 2) begin
                start = 1'b1; dir = ~d; amount = AMT_W'(5); count = IDX_W'(1);
                host_we = 1'b1; host_widx = IDX_W'(NDIG - 1); host_wdata = 64'hDEAD_BEEF_0BAD_F00D;
            end else begin
                start = 1'b0; host_we = 1'b0;
            end
        end
        start = 1'b0; host_we = 1'b0;
        check({tag, " R8 done latency"}, 64'(cyc), 64'(n + 1));
        @(negedge clk);
        check({tag, " R8 done one cycle"}, 64'(done), 64'd0);
        check({tag, " R5 carry_out"}, carry_out, exp_cout);
        for (int i = 0; i < NDIG; i++) begin
            host_ridx = IDX_W'(i);
            #1;
            check($sformatf("%s R10 digit %0d", tag, i), host_rdata, exp_d[i]);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R8 act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 carry_out", carry_out, 64'd0);
        for (int i = 0; i < NDIG; i++) begin
            host_ridx = IDX_W'(i);
            #1;
            check("R1 digit", host_rdata, 64'd0);
            @(negedge clk);
        end
    endtask

    task automatic t_host_port();
        load_random();
        verify_store("R2 host readback");
    endtask

    initial begin
        t_reset();
        t_host_port();
        run_op("R3 left 13",           1'b0, 13,  8,  64'hA5A5_0000_FFFF_1234, 1'b0);
        run_op("R4 right 37",          1'b1, 37,  5,  64'h0123_4567_89AB_CDEF, 1'b0);
        run_op("R6 left whole 64",     1'b0, 64,  6,  64'hCAFE_0000_0000_BABE, 1'b0);
        run_op("R6 right zero",        1'b1, 0,   4,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run_op("R7 right off2",        1'b1, 130, 7,  64'h1111_2222_3333_4444, 1'b0);
        run_op("R7 left off3",         1'b0, 200, 3,  64'h8000_0000_0000_0001, 1'b0);
        run_op("R7 left off1 sub",     1'b0, 71,  5,  64'h7777_0000_5555_0000, 1'b0);
        run_op("R11 clamp",            1'b1, 1,   15, 64'h0000_0000_0000_0003, 1'b0);
        run_op("R9 R2 busy pokes",     1'b0, 9,   5,  64'h0F0F_F0F0_0F0F_F0F0, 1'b1);
        run_op("R12 right one digit",  1'b1, 63,  1,  64'h0000_0000_0000_0001, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule